// File: doc/BRIEF.md
# Link Error Recovery Controller

This block holds the control and status logic that takes one root port of a PCIe-style link into a live recovery mode, and back out of it. It watches a vector of error status bits, each with its own mask bit and its own fatal/nonfatal class. The first unmasked error seen while the feature is switched on sets a sticky recovery status. While that status is held, the controller keeps the link disabled, aborts outbound transactions and blocks inbound ones. It can also drop new transactions, raise a one-cycle interrupt request and report the severity of the entering error. Software sees one 32-bit configuration word.

Software leaves recovery by writing 1 to the status bit. The controller refuses that write while any unmasked error bit is still set. A quiesced flag tells software when no packets are pending in either direction, so it knows when it is safe to clear. When the status drops, the controller asks for the link to retrain. Link training, the packet datapath and interrupt delivery sit outside the block and are reached through plain request and status signals.

Top module: `link_recovery_ctrl`

## Requirements
- R1: A power-on reset (`por_n` low) clears every bit of `cfg_rdata` and deasserts every output.
- R2: `cfg_rdata` shows recovery status at bit 31, quiesced at bit 30, interrupt enable at bit 3, drop at bit 2, severity override at bit 1 and feature enable at bit 0. Bits 29:4 read 0. A write stores `cfg_wdata[3:0]` into bits 3:0, and bits 30:4 of a write have no effect.
- R3: The status bit goes to 1 at the clock edge after a cycle in which any `err_status[i] & ~err_mask[i]` is 1 and the enable bit held 1 before that cycle's write. If the enable bit held 0, the status stays 0.
- R4: While the status bit is 1, `link_disable_o`, `out_abort_o` and `in_block_o` are 1.
- R5: A write with `cfg_wdata[31]`=1 clears the status only if no unmasked error bit is set in that cycle. Otherwise the clear is ignored, and it works once the error bits are cleared or masked.
- R6: In the cycle after a successful clear, `link_retrain_o` is 1 for exactly one cycle, and `link_disable_o`, `out_abort_o` and `in_block_o` are 0.
- R7: The quiesced bit is 1 exactly when the status bit is 1 and both `in_pending` and `out_pending` were zero in the cycle before.
- R8: When the status bit rises with the interrupt enable at 1, `irq_o` is 1 for that one cycle. With the interrupt enable at 0, no pulse occurs.
- R9: `sev_valid_o` pulses together with the status rising. `sev_o` is 0 if the severity override is 1. Otherwise it is 2 if any unmasked set error has `err_fatal` at 1, and 1 if none does.
- R10: Writing the enable bit to 0 while the status is 1 leaves the status at 1 and the port in recovery mode.
- R11: `surprise_down_o` is 1 in a cycle where `link_up_i` falls from 1 to 0 while the status is 0. A fall during recovery mode never raises it.
- R12: `txn_drop_o` is 1 only while the status is 1 and the drop bit is 1.
- R13: A warm reset (`warm_rst_n` low, `por_n` high) keeps bits 31, 30 and 3:0. It clears only the pulse outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears sticky state |
| warm_rst_n | input | 1 | Warm reset, active low, clears non-sticky state only |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration register read value |
| err_status | input | N_ERR | Error status bits |
| err_mask | input | N_ERR | Per-error mask, 1 = masked |
| err_fatal | input | N_ERR | Per-error class, 1 = fatal, 0 = nonfatal |
| in_pending | input | PEND_W | Count of pending inbound packets |
| out_pending | input | PEND_W | Count of pending outbound packets |
| link_up_i | input | 1 | Link state from training logic |
| link_disable_o | output | 1 | Hold link in disabled state |
| link_retrain_o | output | 1 | One-cycle request to retrain the link |
| out_abort_o | output | 1 | Abort outbound transactions |
| in_block_o | output | 1 | Block inbound transactions |
| txn_drop_o | output | 1 | Drop new transactions instead of holding them |
| irq_o | output | 1 | One-cycle interrupt request |
| sev_valid_o | output | 1 | Severity report strobe |
| sev_o | output | 2 | Reported severity: 0 correctable, 1 nonfatal, 2 fatal |
| surprise_down_o | output | 1 | Unexpected link-down indication |

## Verification
The risky collision is a software clear of the status arriving in the same cycle as an unmasked error that is still set. The clear must lose, and it must win once the error is masked. The stimulus table drives that write with the error bit present, then again with the mask set, and checks the status after each edge. A second collision is a write that turns the enable off in the same cycle as a new error arrives. Because entry looks at the enable as it stood before the write, the bench expects recovery to start and then expects a later error to be refused.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

  localparam int REG_W      = 32;
  localparam int BIT_STATUS = 31;
  localparam int BIT_QUIES  = 30;
  localparam int CTL_W      = 4;

  typedef enum logic [1:0] {
    SEV_CORR     = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2
  } sev_e;

  // control field occupies bits CTL_W-1:0 of the register
  typedef struct packed {
    logic inten;
    logic drop;
    logic sevov;
    logic en;
  } ctl_t;

  function automatic sev_e pick_sev(input logic any_fatal, input logic override);
    if (override)       return SEV_CORR;
    else if (any_fatal) return SEV_FATAL;
    else                return SEV_NONFATAL;
  endfunction

  function automatic logic [REG_W-1:0] pack_reg(input logic st, input logic qs, input ctl_t c);
    logic [REG_W-1:0] r;
    r               = '0;
    r[BIT_STATUS]   = st;
    r[BIT_QUIES]    = qs;
    r[CTL_W-1:0]    = c;
    return r;
  endfunction

  function automatic logic both_idle(input logic [31:0] a, input logic [31:0] b);
    return (a == 32'd0) && (b == 32'd0);
  endfunction

endpackage

// File: rtl/lrc_err_detect.sv
module lrc_err_detect #(
  parameter int N_ERR = 8
) (
  input  logic [N_ERR-1:0] err_status,
  input  logic [N_ERR-1:0] err_mask,
  input  logic [N_ERR-1:0] err_fatal,
  output logic             err_hit,
  output logic             any_fatal
);
  logic [N_ERR-1:0] qual;
  logic [N_ERR-1:0] qual_fatal;

  for (genvar i = 0; i < N_ERR; i++) begin : g_src
    assign qual[i]       = err_status[i] & ~err_mask[i];
    assign qual_fatal[i] = qual[i] & err_fatal[i];
  end

  assign err_hit   = |qual;
  assign any_fatal = |qual_fatal;
endmodule

// File: rtl/lrc_cfg_reg.sv
module lrc_cfg_reg
  import lrc_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr_en,
  input  logic             wr_clr,
  input  logic [CTL_W-1:0] wr_ctl,
  input  logic             err_hit,
  output ctl_t             ctl_q,
  output logic             status_q,
  output logic             status_d,
  output logic             set_evt,
  output logic             clr_evt
);
  logic clr_req;

  // entry uses the enable as it stood before any write in this cycle
  assign clr_req  = wr_en & wr_clr;
  assign set_evt  = ctl_q.en & err_hit & ~status_q;
  assign clr_evt  = clr_req & status_q & ~err_hit;
  assign status_d = set_evt | (status_q & ~clr_evt);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctl_q    <= '0;
      status_q <= 1'b0;
    end else begin
      if (wr_en) ctl_q <= ctl_t'(wr_ctl);
      status_q <= status_d;
    end
  end
endmodule

// File: rtl/lrc_quiesce.sv
module lrc_quiesce
  import lrc_pkg::*;
#(
  parameter int PEND_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              status_d,
  input  logic [PEND_W-1:0] in_pending,
  input  logic [PEND_W-1:0] out_pending,
  output logic              quiesced_q
);
  logic idle;

  assign idle = both_idle(32'(in_pending), 32'(out_pending));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) quiesced_q <= 1'b0;
    else        quiesced_q <= status_d & idle;
  end
endmodule

// File: rtl/lrc_pulse_gen.sv
module lrc_pulse_gen
  import lrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_evt,
  input  logic       clr_evt,
  input  logic       inten,
  input  logic       sevov,
  input  logic       any_fatal,
  input  logic       status_q,
  input  logic       link_up_i,
  output logic       irq_o,
  output logic       sev_valid_o,
  output logic [1:0] sev_o,
  output logic       retrain_o,
  output logic       surprise_o
);
  logic link_up_q;
  sev_e sev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o       <= 1'b0;
      sev_valid_o <= 1'b0;
      sev_q       <= SEV_CORR;
      retrain_o   <= 1'b0;
      link_up_q   <= 1'b0;
    end else begin
      irq_o       <= set_evt & inten;
      sev_valid_o <= set_evt;
      if (set_evt) sev_q <= pick_sev(any_fatal, sevov);
      retrain_o   <= clr_evt;
      link_up_q   <= link_up_i;
    end
  end

  assign sev_o      = sev_q;
  // a fall while recovery holds the link disabled is expected, not a surprise
  assign surprise_o = link_up_q & ~link_up_i & ~status_q;
endmodule

// File: rtl/link_recovery_ctrl.sv
module link_recovery_ctrl
  import lrc_pkg::*;
#(
  parameter int N_ERR  = 8,
  parameter int PEND_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst_n,
  input  logic              cfg_wr_en,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [N_ERR-1:0]  err_status,
  input  logic [N_ERR-1:0]  err_mask,
  input  logic [N_ERR-1:0]  err_fatal,
  input  logic [PEND_W-1:0] in_pending,
  input  logic [PEND_W-1:0] out_pending,
  input  logic              link_up_i,
  output logic              link_disable_o,
  output logic              link_retrain_o,
  output logic              out_abort_o,
  output logic              in_block_o,
  output logic              txn_drop_o,
  output logic              irq_o,
  output logic              sev_valid_o,
  output logic [1:0]        sev_o,
  output logic              surprise_down_o
);
  // named internal events, visible to the bound checker
  logic err_hit;
  logic any_fatal;
  ctl_t ctl_q;
  logic status_q;
  logic status_d;
  logic set_evt;
  logic clr_evt;
  logic quiesced_q;
  logic rst_any_n;
  logic unused_wbits;

  assign rst_any_n    = por_n & warm_rst_n;
  assign unused_wbits = ^cfg_wdata[30:CTL_W];

  lrc_err_detect #(.N_ERR(N_ERR)) u_det (
    .err_status (err_status),
    .err_mask   (err_mask),
    .err_fatal  (err_fatal),
    .err_hit    (err_hit),
    .any_fatal  (any_fatal)
  );

  lrc_cfg_reg u_reg (
    .clk      (clk),
    .por_n    (por_n),
    .wr_en    (cfg_wr_en),
    .wr_clr   (cfg_wdata[BIT_STATUS]),
    .wr_ctl   (cfg_wdata[CTL_W-1:0]),
    .err_hit  (err_hit),
    .ctl_q    (ctl_q),
    .status_q (status_q),
    .status_d (status_d),
    .set_evt  (set_evt),
    .clr_evt  (clr_evt)
  );

  lrc_quiesce #(.PEND_W(PEND_W)) u_qsc (
    .clk         (clk),
    .por_n       (por_n),
    .status_d    (status_d),
    .in_pending  (in_pending),
    .out_pending (out_pending),
    .quiesced_q  (quiesced_q)
  );

  lrc_pulse_gen u_pls (
    .clk         (clk),
    .rst_n       (rst_any_n),
    .set_evt     (set_evt),
    .clr_evt     (clr_evt),
    .inten       (ctl_q.inten),
    .sevov       (ctl_q.sevov),
    .any_fatal   (any_fatal),
    .status_q    (status_q),
    .link_up_i   (link_up_i),
    .irq_o       (irq_o),
    .sev_valid_o (sev_valid_o),
    .sev_o       (sev_o),
    .retrain_o   (link_retrain_o),
    .surprise_o  (surprise_down_o)
  );

  assign cfg_rdata      = pack_reg(status_q, quiesced_q, ctl_q);
  assign link_disable_o = status_q;
  assign out_abort_o    = status_q;
  assign in_block_o     = status_q;
  assign txn_drop_o     = status_q & ctl_q.drop;
endmodule

// File: rtl/lrc_checker.sv
module lrc_checker (
  input logic        clk,
  input logic        por_n,
  input logic        warm_rst_n,
  input logic        cfg_wr_en,
  input logic        cfg_wclr,
  input logic        en_q,
  input logic        err_hit,
  input logic        status_q,
  input logic        quiesced_q,
  input logic        link_disable_o,
  input logic        out_abort_o,
  input logic        in_block_o,
  input logic        txn_drop_o,
  input logic        link_retrain_o,
  input logic        irq_o,
  input logic        sev_valid_o,
  input logic [1:0]  sev_o,
  input logic        surprise_down_o
);
  p_entry_gated_r3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(status_q) |-> ($past(en_q) && $past(err_hit)));

  p_clear_blocked_r5: assert property (@(posedge clk) disable iff (!por_n)
    (status_q && err_hit) |=> status_q);

  p_only_w1c_exits_r10: assert property (@(posedge clk) disable iff (!por_n)
    (status_q && !(cfg_wr_en && cfg_wclr)) |=> status_q);

  p_hold_link_r4: assert property (@(posedge clk) disable iff (!por_n)
    status_q |-> (link_disable_o && out_abort_o && in_block_o));

  p_retrain_r6: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    $fell(status_q) |-> link_retrain_o);

  p_irq_on_rise_r8: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    irq_o |-> $rose(status_q));

  p_quies_in_mode_r7: assert property (@(posedge clk) disable iff (!por_n)
    quiesced_q |-> status_q);

  p_no_surprise_r11: assert property (@(posedge clk) disable iff (!por_n)
    surprise_down_o |-> !status_q);

  p_sev_legal_r9: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    sev_valid_o |-> (sev_o != 2'd3 && $rose(status_q)));

  p_drop_in_mode_r12: assert property (@(posedge clk) disable iff (!por_n)
    txn_drop_o |-> status_q);
endmodule

bind link_recovery_ctrl lrc_checker u_chk (
  .clk             (clk),
  .por_n           (por_n),
  .warm_rst_n      (warm_rst_n),
  .cfg_wr_en       (cfg_wr_en),
  .cfg_wclr        (cfg_wdata[31]),
  .en_q            (ctl_q.en),
  .err_hit         (err_hit),
  .status_q        (status_q),
  .quiesced_q      (quiesced_q),
  .link_disable_o  (link_disable_o),
  .out_abort_o     (out_abort_o),
  .in_block_o      (in_block_o),
  .txn_drop_o      (txn_drop_o),
  .link_retrain_o  (link_retrain_o),
  .irq_o           (irq_o),
  .sev_valid_o     (sev_valid_o),
  .sev_o           (sev_o),
  .surprise_down_o (surprise_down_o)
);

// File: tb/test_link_recovery_ctrl.sv
module test_link_recovery_ctrl;
  localparam int N_ERR  = 8;
  localparam int PEND_W = 8;
  localparam int ROWS   = 10;

  logic              clk = 1'b0;
  logic              por_n = 1'b0;
  logic              warm_rst_n = 1'b1;
  logic              cfg_wr_en = 1'b0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic [N_ERR-1:0]  err_status = '0;
  logic [N_ERR-1:0]  err_mask = '0;
  logic [N_ERR-1:0]  err_fatal = '0;
  logic [PEND_W-1:0] in_pending = '0;
  logic [PEND_W-1:0] out_pending = '0;
  logic              link_up_i = 1'b0;
  logic              link_disable_o, link_retrain_o, out_abort_o, in_block_o;
  logic              txn_drop_o, irq_o, sev_valid_o, surprise_down_o;
  logic [1:0]        sev_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  link_recovery_ctrl #(.N_ERR(N_ERR), .PEND_W(PEND_W)) i_link_recovery_ctrl (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .err_status(err_status), .err_mask(err_mask), .err_fatal(err_fatal),
    .in_pending(in_pending), .out_pending(out_pending), .link_up_i(link_up_i),
    .link_disable_o(link_disable_o), .link_retrain_o(link_retrain_o),
    .out_abort_o(out_abort_o), .in_block_o(in_block_o), .txn_drop_o(txn_drop_o),
    .irq_o(irq_o), .sev_valid_o(sev_valid_o), .sev_o(sev_o),
    .surprise_down_o(surprise_down_o)
  );

  // row: wr, clr, ctl[3:0], err, mask, fatal | exp status, irq, sev_valid, sev
  localparam logic [34:0] TBL [ROWS] = '{
    {1'b1, 1'b0, 4'b1001, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0},
    {1'b0, 1'b0, 4'b0000, 8'h01, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 2'd1},
    {1'b1, 1'b1, 4'b1001, 8'h01, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0},
    {1'b0, 1'b0, 4'b0000, 8'h01, 8'h01, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0},
    {1'b1, 1'b1, 4'b1001, 8'h01, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0},
    {1'b0, 1'b0, 4'b0000, 8'h04, 8'h00, 8'h04, 1'b1, 1'b1, 1'b1, 2'd2},
    {1'b1, 1'b1, 4'b1011, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0},
    {1'b0, 1'b0, 4'b0000, 8'h10, 8'h00, 8'h10, 1'b1, 1'b1, 1'b1, 2'd0},
    {1'b1, 1'b1, 4'b0000, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0},
    {1'b0, 1'b0, 4'b0000, 8'h02, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic wr(input logic clr, input logic [3:0] ctl);
    cfg_wr_en = 1'b1;
    cfg_wdata = {clr, 27'd0, ctl};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", cfg_rdata, 32'h0);
    chk("R1 outputs", {link_disable_o, link_retrain_o, out_abort_o, in_block_o,
                       txn_drop_o, irq_o, sev_valid_o, surprise_down_o}, 0);

    // R2: layout, reserved bits and bit 30 ignore writes
    cfg_wr_en = 1'b1; cfg_wdata = 32'h7FFF_FFF5;
    step();
    chk("R2 layout", cfg_rdata, 32'h0000_0005);
    wr(1'b0, 4'b0000); step();

    // table: entry, blocked clear (R5), severity (R9), irq (R8), enable gate (R3)
    for (int r = 0; r < ROWS; r++) begin
      cfg_wr_en  = TBL[r][34];
      cfg_wdata  = {TBL[r][33], 27'd0, TBL[r][32:29]};
      err_status = TBL[r][28:21];
      err_mask   = TBL[r][20:13];
      err_fatal  = TBL[r][12:5];
      step();
      chk($sformatf("R3/R5 status row %0d", r), cfg_rdata[31], TBL[r][4]);
      chk($sformatf("R8 irq row %0d", r), irq_o, TBL[r][3]);
      chk($sformatf("R9 sev_valid row %0d", r), sev_valid_o, TBL[r][2]);
      if (TBL[r][2]) chk($sformatf("R9 sev row %0d", r), sev_o, TBL[r][1:0]);
    end
    err_status = '0; err_mask = '0; err_fatal = '0;

    // R4, R10, R6, R8 (no irq without enable)
    wr(1'b0, 4'b0001); step();
    err_status = 8'h01; step();
    chk("R4 hold", {link_disable_o, out_abort_o, in_block_o}, 3'b111);
    chk("R8 no irq", irq_o, 0);
    chk("R12 no drop", txn_drop_o, 0);
    err_status = 8'h00; wr(1'b0, 4'b0000); step();
    chk("R10 status kept", cfg_rdata[31], 1);
    chk("R10 enable off", cfg_rdata[0], 0);
    chk("R10 still held", link_disable_o, 1);
    wr(1'b1, 4'b0000); step();
    chk("R6 retrain", link_retrain_o, 1);
    chk("R6 released", {link_disable_o, out_abort_o, in_block_o}, 3'b000);
    step();
    chk("R6 retrain pulse", link_retrain_o, 0);

    // R7 quiesce, R12 drop
    wr(1'b0, 4'b0101); in_pending = 8'd3; step();
    err_status = 8'h01; step();
    chk("R7 busy", cfg_rdata[30], 0);
    chk("R12 drop", txn_drop_o, 1);
    err_status = 8'h00; in_pending = 8'd0; out_pending = 8'd2; step();
    chk("R7 out busy", cfg_rdata[30], 0);
    out_pending = 8'd0; step();
    chk("R7 quiesced", cfg_rdata[30], 1);

    // R13 warm reset keeps sticky bits
    warm_rst_n = 1'b0; step();
    warm_rst_n = 1'b1; step();
    chk("R13 sticky", cfg_rdata, 32'hC000_0005);

    // R11 surprise link-down
    link_up_i = 1'b1; step();
    link_up_i = 1'b0; #1;
    chk("R11 in recovery", surprise_down_o, 0);
    step();
    wr(1'b1, 4'b0101); step();
    link_up_i = 1'b1; step();
    link_up_i = 1'b0; #1;
    chk("R11 surprise", surprise_down_o, 1);
    step();
    chk("R11 pulse ends", surprise_down_o, 0);

    // R3 same-cycle: enable cleared by write as error arrives
    wr(1'b0, 4'b0001); step();
    err_status = 8'h01; wr(1'b0, 4'b0000); step();
    chk("R3 old enable", cfg_rdata[31], 1);
    err_status = 8'h00; wr(1'b1, 4'b0000); step();
    err_status = 8'h01; step();
    chk("R3 disabled", cfg_rdata[31], 0);
    err_status = 8'h00;

    // R1 power-on reset clears sticky bits
    wr(1'b0, 4'b1111); step();
    err_status = 8'h01; step();
    err_status = 8'h00;
    por_n = 1'b0; step();
    por_n = 1'b1; step();
    chk("R1 por clears", cfg_rdata, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule